// File: doc/BRIEF.md
# Multiword DMA Strobe Engine (host side)

This block is the host end of a disk-style multiword DMA channel. Software-facing logic picks a timing mode, a direction and a word count, and pulses `start`. The engine waits for the device's request line, acknowledges it and then issues one read or write strobe per 16-bit word. Strobe width, recovery and write-data hold are counted in clock ticks, derived at elaboration from nanosecond minimums and the `CLK_PERIOD_NS` parameter by rounding up.

Per mode, the strobe lasts the larger of the minimum strobe width and the minimum write setup, both in ticks. Recovery lasts the larger of (cycle minus strobe) and the write hold. With a 10 ns clock this gives strobe/recovery of 48/48, 24/24 and 12/12 ticks for modes 0, 1 and 2. Mode code 3 is not a valid mode and runs with mode 0 timing.

The controller has six states. `ST_IDLE` waits for `start`. `ST_WAIT_REQ` keeps the acknowledge negated until the request is seen. `ST_ACK` asserts the acknowledge for one tick before the first strobe. `ST_STROBE` drives the strobe low. `ST_RECOVER` keeps the strobe high while write data is still held. `ST_DONE` gives the completion pulse. The transitions are:
- `ST_IDLE` goes to `ST_WAIT_REQ` on `start`, or to `ST_DONE` when the count is zero.
- `ST_WAIT_REQ` goes to `ST_ACK` when the request is asserted.
- `ST_ACK` goes to `ST_STROBE` if the request is still asserted, and otherwise back to `ST_WAIT_REQ`.
- `ST_STROBE` goes to `ST_RECOVER` when the strobe timer expires.
- `ST_RECOVER` leaves when its timer expires. It goes to `ST_DONE` if no words remain, to `ST_STROBE` if the request is asserted, and otherwise to `ST_WAIT_REQ`.
- `ST_DONE` returns to `ST_IDLE`.

Top module: `mdma_host`

## Requirements
- R1: After reset `dmack_n`, `dior_n` and `diow_n` are 1, and `dd_oe`, `done`, `rd_valid` and `wr_take` are 0.
- R2: `dmack_n` falls only when `dmarq` was 1 at the edge that asserts it. While `dmarq` stays 0 after `start`, `dmack_n` stays 1 and no strobe occurs. The first strobe falls exactly one clock after `dmack_n` falls. A strobe is never low while `dmack_n` is 1.
- R3: Each strobe stays low for exactly the strobe tick count of the latched mode: 48, 24 or 12 clocks for modes 0, 1 and 2 at 10 ns. Mode code 3 gives 48.
- R4: Within an unbroken acknowledge, consecutive strobe falls are exactly (strobe + recovery) clocks apart: 96, 48 or 24 at 10 ns.
- R5: On a write (`dir_read`=0), `wr_word` is captured at the edge that ends a cycle with `wr_take`=1. `dd_out` presents that word with `dd_oe`=1 and stays unchanged for the whole time `diow_n` is low.
- R6: On a read (`dir_read`=1), `dd_in` is captured at the edge that raises `dior_n`. It appears on `rd_word` with `rd_valid`=1 for the one following clock.
- R7: If `dmarq` is 0 when recovery ends, `dmack_n` returns to 1 and no strobe is issued until `dmarq` is 1 again.
- R8: A burst issues exactly `word_total` strobes. `done` is then high for exactly one clock, with `dmack_n` at 1.
- R9: A `start` with `word_total`=0 raises `done` one clock later, with no acknowledge and no strobe.
- R10: A `start` pulse that arrives while a burst is running is ignored: the word count and mode of the running burst are unchanged.
- R11: `dior_n` and `diow_n` are never low at the same time, and only the strobe of the latched direction is used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 2 | Timing mode 0..2 (3 runs as mode 0), latched at start |
| dir_read | input | 1 | 1 = read from device, 0 = write, latched at start |
| word_total | input | WCNT_W | Words in the burst, latched at start |
| start | input | 1 | One-clock request to begin a burst (ignored unless idle) |
| dmarq | input | 1 | Device DMA request, active high |
| dd_in | input | 16 | Read data from the device bus |
| wr_word | input | 16 | Next word to write; taken when `wr_take` is high |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | 16 | Write data toward the device bus |
| dd_oe | output | 1 | Output enable for `dd_out` |
| wr_take | output | 1 | The current `wr_word` is captured at the next edge |
| rd_word | output | 16 | Captured read word |
| rd_valid | output | 1 | `rd_word` holds a new word this clock |
| done | output | 1 | One-clock pulse when the burst is finished |

## Verification
A wrong tick count or timer load shows up at the ports as a strobe that is one or more clocks too long or too short. It is visible on the first strobe of the burst, and in the fall-to-fall spacing of the second word. A state machine that ignores the request line shows as an acknowledge or strobe while `dmarq` is low, within one clock of the stall. A word counter off by one shows as one strobe too many or too few, or as `done` arriving early, at the end of the burst. Wrong data capture shows on the first word as a mismatch between the pushed expectation and `dd_out` or `rd_word`.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    localparam int TICK_W = 16;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_REQ,
        ST_ACK,
        ST_STROBE,
        ST_RECOVER,
        ST_DONE
    } mdma_state_e;

    typedef struct packed {
        logic [TICK_W-1:0] strobe;
        logic [TICK_W-1:0] recover;
    } mdma_ticks_t;

    // Nanosecond minimums per mode; codes other than 1 and 2 use mode 0.
    function automatic int unsigned cycle_ns(input int unsigned m);
        case (m)
            1:       return 480;
            2:       return 240;
            default: return 960;
        endcase
    endfunction

    function automatic int unsigned strobe_ns(input int unsigned m);
        case (m)
            1:       return 240;
            2:       return 120;
            default: return 480;
        endcase
    endfunction

    function automatic int unsigned wsetup_ns(input int unsigned m);
        case (m)
            1:       return 100;
            2:       return 35;
            default: return 250;
        endcase
    endfunction

    function automatic int unsigned whold_ns(input int unsigned m);
        case (m)
            1:       return 30;
            2:       return 20;
            default: return 50;
        endcase
    endfunction

    function automatic int unsigned ns_to_ticks(input int unsigned ns, input int unsigned period);
        int unsigned t;
        t = (ns + period - 1) / period;
        return (t == 0) ? 1 : t;
    endfunction

endpackage

// File: rtl/mdma_timing_lut.sv
module mdma_timing_lut
    import mdma_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10
) (
    input  logic [1:0]  mode,
    output mdma_ticks_t ticks
);

    localparam int NMODES = 4;

    mdma_ticks_t table_q [NMODES];

    for (genvar g = 0; g < NMODES; g++) begin : g_mode
        localparam int unsigned WID_T = ns_to_ticks(strobe_ns(g), CLK_PERIOD_NS);
        localparam int unsigned SET_T = ns_to_ticks(wsetup_ns(g), CLK_PERIOD_NS);
        localparam int unsigned STB_T = (WID_T > SET_T) ? WID_T : SET_T;
        localparam int unsigned CYC_T = ns_to_ticks(cycle_ns(g), CLK_PERIOD_NS);
        localparam int unsigned HLD_T = ns_to_ticks(whold_ns(g), CLK_PERIOD_NS);
        localparam int unsigned GAP_T = (CYC_T > STB_T) ? (CYC_T - STB_T) : 0;
        localparam int unsigned REC_T = (GAP_T > HLD_T) ? GAP_T : HLD_T;
        assign table_q[g].strobe  = TICK_W'(STB_T);
        assign table_q[g].recover = TICK_W'(REC_T);
    end

    assign ticks = table_q[mode];

endmodule

// File: rtl/mdma_tick_timer.sv
module mdma_tick_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/mdma_word_ctr.sv
module mdma_word_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         none_left
);

    logic [W-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (load) begin
            left_q <= load_val;
        end else if (dec && left_q != '0) begin
            left_q <= left_q - 1'b1;
        end
    end

    assign none_left = (left_q == '0);

endmodule

// File: rtl/mdma_host.sv
module mdma_host
    import mdma_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_NS = 10,
    parameter int          WCNT_W        = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_sel,
    input  logic              dir_read,
    input  logic [WCNT_W-1:0] word_total,
    input  logic              start,
    input  logic              dmarq,
    input  logic [15:0]       dd_in,
    input  logic [15:0]       wr_word,
    output logic              dmack_n,
    output logic              dior_n,
    output logic              diow_n,
    output logic [15:0]       dd_out,
    output logic              dd_oe,
    output logic              wr_take,
    output logic [15:0]       rd_word,
    output logic              rd_valid,
    output logic              done
);

    mdma_state_e state_q, state_d;

    logic [1:0]        mode_q;
    logic              rd_q;
    mdma_ticks_t       ticks;
    logic [TICK_W-1:0] strobe_len;
    logic              t_expired;
    logic              none_left;
    logic              accept;
    logic              enter_strobe;
    logic              enter_recover;
    logic [TICK_W-1:0] timer_val;

    mdma_timing_lut #(.CLK_PERIOD_NS(CLK_PERIOD_NS)) u_lut (
        .mode  (mode_q),
        .ticks (ticks)
    );

    assign strobe_len = ticks.strobe;

    assign accept        = (state_q == ST_IDLE) && start;
    assign enter_strobe  = (state_d == ST_STROBE) && (state_q != ST_STROBE);
    assign enter_recover = (state_q == ST_STROBE) && t_expired;
    assign timer_val     = enter_strobe ? (ticks.strobe - 1'b1) : (ticks.recover - 1'b1);

    mdma_tick_timer #(.W(TICK_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (enter_strobe | enter_recover),
        .load_val (timer_val),
        .expired  (t_expired)
    );

    mdma_word_ctr #(.W(WCNT_W)) u_words (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_val  (word_total),
        .dec       (enter_recover),
        .none_left (none_left)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decode
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (word_total == '0) ? ST_DONE : ST_WAIT_REQ;
                end
            end
            ST_WAIT_REQ: begin
                if (dmarq) state_d = ST_ACK;
            end
            ST_ACK: begin
                state_d = dmarq ? ST_STROBE : ST_WAIT_REQ;
            end
            ST_STROBE: begin
                if (t_expired) state_d = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (t_expired) begin
                    if (none_left)  state_d = ST_DONE;
                    else if (dmarq) state_d = ST_STROBE;
                    else            state_d = ST_WAIT_REQ;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Burst configuration and data path registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q   <= 2'd0;
            rd_q     <= 1'b0;
            dd_out   <= 16'h0000;
            rd_word  <= 16'h0000;
            rd_valid <= 1'b0;
        end else begin
            if (accept) begin
                mode_q <= mode_sel;
                rd_q   <= dir_read;
            end
            if (enter_strobe && !rd_q) begin
                dd_out <= wr_word;
            end
            rd_valid <= enter_recover && rd_q;
            if (enter_recover && rd_q) begin
                rd_word <= dd_in;
            end
        end
    end

    // Output decode from state
    always_comb begin
        dmack_n = 1'b1;
        dior_n  = 1'b1;
        diow_n  = 1'b1;
        dd_oe   = 1'b0;
        done    = 1'b0;
        wr_take = enter_strobe && !rd_q;
        unique case (state_q)
            ST_IDLE, ST_WAIT_REQ: ;
            ST_ACK: begin
                dmack_n = 1'b0;
            end
            ST_STROBE: begin
                dmack_n = 1'b0;
                dior_n  = !rd_q;
                diow_n  = rd_q;
                dd_oe   = !rd_q;
            end
            ST_RECOVER: begin
                dmack_n = 1'b0;
                dd_oe   = !rd_q;
            end
            ST_DONE: begin
                done = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mdma_host_chk.sv
module mdma_host_chk #(
    parameter int TW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dmarq,
    input logic          dmack_n,
    input logic          dior_n,
    input logic          diow_n,
    input logic          dd_oe,
    input logic [15:0]   dd_out,
    input logic          done,
    input logic [TW-1:0] strobe_len
);

    logic          strobe_hi;
    logic [TW-1:0] low_cnt;

    assign strobe_hi = dior_n && diow_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!strobe_hi) begin
            low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    p_ack_needs_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dmack_n) |-> $past(dmarq));

    p_strobe_under_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_hi |-> !dmack_n);

    p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_hi) |-> (low_cnt == strobe_len));

    p_wdata_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!diow_n && $past(!diow_n)) |-> ($stable(dd_out) && dd_oe));

    p_strobe_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_hi) |-> $past(dmarq));

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> dmack_n);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

endmodule

bind mdma_host mdma_host_chk #(.TW(mdma_pkg::TICK_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dmarq      (dmarq),
    .dmack_n    (dmack_n),
    .dior_n     (dior_n),
    .diow_n     (diow_n),
    .dd_oe      (dd_oe),
    .dd_out     (dd_out),
    .done       (done),
    .strobe_len (strobe_len)
);

// File: tb/mdma_host_tb.sv
`timescale 1ns/1ps
module mdma_host_tb;

    localparam int PER = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        dir_read = 1'b0;
    logic [15:0] word_total = 16'd0;
    logic        start = 1'b0;
    logic        dmarq = 1'b0;
    logic [15:0] dd_in;
    logic [15:0] wr_word;
    logic        dmack_n, dior_n, diow_n, dd_oe, wr_take, rd_valid, done;
    logic [15:0] dd_out, rd_word;

    always #5 clk = ~clk;

    mdma_host u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .dir_read(dir_read),
        .word_total(word_total), .start(start), .dmarq(dmarq), .dd_in(dd_in),
        .wr_word(wr_word), .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n),
        .dd_out(dd_out), .dd_oe(dd_oe), .wr_take(wr_take), .rd_word(rd_word),
        .rd_valid(rd_valid), .done(done)
    );

    int tests = 0;
    int fails = 0;
    int cyc = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [15:0] wval(input int i);
        return 16'h3000 ^ 16'(i * 16'h0111);
    endfunction
    function automatic logic [15:0] rval(input int i);
        return 16'hC000 + 16'(i);
    endfunction
    function automatic int ticks_of(input int ns);
        return (ns + PER - 1) / PER;
    endfunction

    // Write source and device read model
    int w_ptr = 0;
    int r_seq = 0;
    always @(posedge clk) if (wr_take) w_ptr <= w_ptr + 1;
    assign wr_word = wval(w_ptr);
    assign dd_in   = rval(r_seq);

    // Scoreboard
    logic [15:0] exp_q[$];
    int w_issue = 0;
    int r_issue = 0;
    int exp_w = 0;
    int exp_p = 0;
    int stb_cnt = 0;
    int done_cnt = 0;

    // Monitor
    bit prev_low = 0;
    bit prev_done = 0;
    bit fall_valid = 0;
    int last_fall = 0;
    int width = 0;
    logic [15:0] held;

    always @(negedge clk) begin
        bit lowv;
        cyc++;
        lowv = !dior_n || !diow_n;
        if (rst_n) begin
            if (!dior_n && !diow_n) chk(0, "R11 both strobes", 1, 0);
            if (lowv && !prev_low) begin
                stb_cnt++;
                width = 1;
                if (fall_valid) chk(cyc - last_fall == exp_p, "R4 strobe spacing", cyc - last_fall, exp_p);
                last_fall = cyc;
                fall_valid = 1;
                if (!diow_n) begin
                    if (exp_q.size() == 0) chk(0, "R5 unexpected write", 0, 1);
                    else begin
                        logic [15:0] e;
                        e = exp_q.pop_front();
                        chk(dd_out == e, "R5 write word", dd_out, e);
                    end
                    chk(dd_oe == 1'b1, "R5 output enable", dd_oe, 1);
                    held = dd_out;
                end
            end else if (lowv) begin
                width++;
                if (!diow_n && dd_out != held) chk(0, "R5 data moved", dd_out, held);
            end
            if (!lowv && prev_low) begin
                chk(width == exp_w, "R3 strobe width", width, exp_w);
                if (dir_read) r_seq <= r_seq + 1;
            end
            if (dmack_n) fall_valid = 0;
            if (rd_valid) begin
                if (exp_q.size() == 0) chk(0, "R6 unexpected read", 0, 1);
                else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    chk(rd_word == e, "R6 read word", rd_word, e);
                end
            end
            if (done) begin
                done_cnt++;
                if (prev_done) chk(0, "R8 done width", 2, 1);
                chk(dmack_n == 1'b1, "R8 ack released at done", dmack_n, 1);
            end
        end
        prev_low  = lowv;
        prev_done = done;
    end

    // Driver
    int done_before = 0;

    task automatic begin_burst(input logic [1:0] m, input bit rd, input int n);
        int mi;
        mi = (m == 2'd3) ? 0 : int'(m);
        exp_w = (mi == 1) ? ticks_of(240) : (mi == 2) ? ticks_of(120) : ticks_of(480);
        exp_p = (mi == 1) ? ticks_of(480) : (mi == 2) ? ticks_of(240) : ticks_of(960);
        for (int i = 0; i < n; i++) begin
            if (rd) begin exp_q.push_back(rval(r_issue)); r_issue++; end
            else    begin exp_q.push_back(wval(w_issue)); w_issue++; end
        end
        @(negedge clk);
        stb_cnt     = 0;
        done_before = done_cnt;
        mode_sel    = m;
        dir_read    = rd;
        word_total  = 16'(n);
        start       = 1'b1;
        @(negedge clk);
        start       = 1'b0;
    endtask

    task automatic end_burst(input int n, input string req);
        int guard;
        guard = 0;
        while (done_cnt == done_before && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(done_cnt == done_before + 1, "R8 done pulse seen", done_cnt - done_before, 1);
        chk(stb_cnt == n, req, stb_cnt, n);
        chk(exp_q.size() == 0, "R8 all words delivered", exp_q.size(), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic wait_strobes(input int n);
        int guard;
        guard = 0;
        while (stb_cnt < n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    // Watchdog
    initial begin
        #(150000 * PER);
        fails++;
        tests++;
        $display("FAIL watchdog: actual expired expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs in reset
        chk(dmack_n && dior_n && diow_n, "R1 strobes idle in reset", {dmack_n, dior_n, diow_n}, 3'b111);
        chk(!dd_oe && !done && !rd_valid && !wr_take, "R1 flags low in reset",
            {dd_oe, done, rd_valid, wr_take}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        dmarq = 1'b1;
        // Mode 2 write burst
        begin_burst(2'd2, 1'b0, 4);
        end_burst(4, "R8 mode2 write count");
        // Mode 1 read burst
        begin_burst(2'd1, 1'b1, 3);
        end_burst(3, "R8 mode1 read count");
        // Mode 0 write
        begin_burst(2'd0, 1'b0, 2);
        end_burst(2, "R3 mode0 write count");
        // Mode code 3 falls back to mode 0 timing (R3)
        begin_burst(2'd3, 1'b1, 2);
        end_burst(2, "R3 mode3 read count");

        // R7: request dropped mid-burst
        begin_burst(2'd2, 1'b0, 4);
        wait_strobes(2);
        dmarq = 1'b0;
        repeat (40) @(negedge clk);
        chk(dmack_n == 1'b1, "R7 ack released while paused", dmack_n, 1);
        chk(stb_cnt == 2, "R7 no strobe while paused", stb_cnt, 2);
        dmarq = 1'b1;
        end_burst(4, "R7 burst resumes to full count");

        // R2: no acknowledge before request
        dmarq = 1'b0;
        begin_burst(2'd1, 1'b1, 2);
        repeat (20) @(negedge clk);
        chk(dmack_n == 1'b1, "R2 ack waits for request", dmack_n, 1);
        chk(stb_cnt == 0, "R2 no strobe before request", stb_cnt, 0);
        dmarq = 1'b1;
        begin
            int guard;
            guard = 0;
            while (dmack_n && guard < 100) begin @(negedge clk); guard++; end
        end
        chk(dior_n == 1'b1, "R2 ack precedes strobe", dior_n, 1);
        @(negedge clk);
        chk(dior_n == 1'b0, "R2 strobe one clock after ack", dior_n, 0);
        end_burst(2, "R2 burst count");

        // R9: zero word count
        begin_burst(2'd2, 1'b0, 0);
        chk(done == 1'b1, "R9 done right after start", done, 1);
        chk(dmack_n == 1'b1, "R9 no ack", dmack_n, 1);
        end_burst(0, "R9 no strobes");

        // R10: start while busy ignored
        begin_burst(2'd2, 1'b0, 3);
        wait_strobes(1);
        @(negedge clk);
        mode_sel   = 2'd0;
        word_total = 16'd9;
        start      = 1'b1;
        @(negedge clk);
        start      = 1'b0;
        end_burst(3, "R10 busy start ignored");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule